// File: doc/BRIEF.md
# AXI transaction rule checker

This block watches one AXI4 connection passively and reports transaction-level rule breaks, not stalls. Every address handshake is tested against a burst-length cap and, when the connection does not accept narrow transfers, against the full bus width. Read and write responses are scanned for slave and decode errors. Accepted reads and writes are queued in bounded in-order trackers that record each burst length. The trackers let the block count data beats, spot a misplaced last beat, and flag traffic that exceeds or precedes the tracked transactions.

Each rule sets one bit in an error vector. A bit stays set until reset. Two status outputs give the number of reads and writes still outstanding. A parameter selects a reduced rule set that keeps only the rules whose breach can stall the interconnect: tracker overflow, tracker underflow and last-beat placement. The block assumes in-order completion, and write data must not lead its address.

Top module: `axi_rule_monitor`

## Requirements
- R1: While reset is applied, err_flags is all zero and both outstanding counts are zero. Reset is asserted asynchronously and released on the second rising clock edge after rst_n goes high.
- R2: An address handshake whose beat count (len + 1) exceeds MAX_BURST_LEN sets err_flags[0] for reads and err_flags[1] for writes. A beat count equal to MAX_BURST_LEN does not set either bit.
- R3: With NARROW_OK = 0, an address handshake whose size code is below log2(DATA_BYTES) sets err_flags[2] for reads and err_flags[3] for writes. With NARROW_OK = 1 these bits are never set.
- R4: With RESP_CHECK = 1, a read beat handshake with response 2'b10 or 2'b11 sets err_flags[4], and a write response handshake with either value sets err_flags[5]. Responses 2'b00 and 2'b01 never set these bits. With RESP_CHECK = 0 these bits are never set.
- R5: rd_outstanding counts accepted read addresses minus read beats carrying last. wr_outstanding counts accepted write addresses that have not yet received a write response handshake.
- R6: An address handshake that arrives while its tracker already holds RD_DEPTH reads (or WR_DEPTH writes) sets err_flags[6] for reads or err_flags[7] for writes. That transaction is not recorded, so the count does not change.
- R7: A read beat handshake while no read is outstanding sets err_flags[8]. A write data beat with no tracked write address, or a write response with no completed write burst, sets err_flags[9].
- R8: Beats are counted from zero within a burst. A read beat whose last flag differs from (beat index == len) sets err_flags[10], and a write data beat with the same mismatch sets err_flags[11]. A beat carrying last ends the burst.
- R9: Once set, every err_flags bit stays set until reset. A flag appears at the rising edge that samples the offending handshake.
- R10: With LIGHT_MODE = 1, err_flags[5:0] are never set. Bits 6 to 11 behave as without this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_len | input | 8 | Read burst length minus one |
| ar_size | input | 3 | Read transfer size code (log2 bytes) |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_last | input | 1 | Read last beat |
| r_resp | input | 2 | Read response |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_len | input | 8 | Write burst length minus one |
| aw_size | input | 3 | Write transfer size code |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Write last beat |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | input | 2 | Write response code |
| err_flags | output | 12 | Sticky rule-violation bits |
| rd_outstanding | output | clog2(RD_DEPTH+1) | Reads in flight |
| wr_outstanding | output | clog2(WR_DEPTH+1) | Writes in flight |

## Verification
The bench sends a burst of exactly the cap and then one beat more. A comparison that is off by one either flags the legal burst or passes the long one. An exclusive-okay response must stay quiet, so a checker that tests only the high response bit correctly passes but one that flags any non-zero code fails. A fifth request into a full tracker must set the overflow bit and leave the count at the depth; a tracker that wraps shows a count of zero or one. Last flags placed early and late, a response before any burst completes, and concurrent address and data handshakes exercise the beat counter, the underflow rules and same-cycle push and pop. Three configurations run side by side so that a mode mask that leaks shows up at once.

// File: rtl/axi_rule_pkg.sv
package axi_rule_pkg;

  localparam int ERR_W = 12;

  typedef enum int {
    E_AR_LEN    = 0,
    E_AW_LEN    = 1,
    E_AR_NARROW = 2,
    E_AW_NARROW = 3,
    E_R_RESP    = 4,
    E_B_RESP    = 5,
    E_RD_OVF    = 6,
    E_WR_OVF    = 7,
    E_RD_UNF    = 8,
    E_WR_UNF    = 9,
    E_R_LAST    = 10,
    E_W_LAST    = 11
  } err_idx_e;

  // rules kept by the reduced (stall-only) rule set
  localparam logic [ERR_W-1:0] STALL_RULES = 12'hFC0;

  function automatic logic resp_is_err(input logic [1:0] code);
    return (code == 2'b10) || (code == 2'b11);
  endfunction

endpackage

// File: rtl/arm_rst_sync.sv
module arm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/arm_len_fifo.sv
module arm_len_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_len,
  input  logic                       pop,
  output logic [W-1:0]               head_len,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULL_V   = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_en;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    ptr_en = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_len;
  end

  assign head_len = mem[rp_q];
  assign count    = cnt_q;

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != FULL_V)); // R6
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R7

endmodule

// File: rtl/arm_beat_check.sv
module arm_beat_check #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         beat,
  input  logic         last,
  input  logic [W-1:0] exp_len,
  output logic         last_err
);

  localparam int CW = W + 1;

  logic [CW-1:0] idx_q, idx_d;
  logic          at_end;

  always_comb begin
    at_end = (idx_q == {1'b0, exp_len});
    idx_d  = idx_q;
    if (beat) begin
      if (last)               idx_d = '0;
      else if (idx_q != '1)   idx_d = idx_q + 1'b1;
    end
    last_err = beat && (last != at_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (beat) idx_q <= idx_d;
  end

  AST_BEAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last) |=> (idx_q == '0)); // R8

endmodule

// File: rtl/arm_attr_check.sv
module arm_attr_check #(
  parameter int MAX_BURST_LEN = 16,
  parameter int DATA_BYTES    = 8,
  parameter bit NARROW_OK     = 1'b0
) (
  input  logic [7:0] len,
  input  logic [2:0] size,
  output logic       len_bad,
  output logic       narrow_bad
);

  localparam logic [9:0] MAX_V   = 10'(MAX_BURST_LEN);
  localparam logic [2:0] FULL_SZ = 3'($clog2(DATA_BYTES));

  logic [8:0] beats;

  always_comb begin
    beats      = {1'b0, len} + 9'd1;
    len_bad    = ({1'b0, beats} > MAX_V);
    narrow_bad = !NARROW_OK && (size < FULL_SZ);
  end

endmodule

// File: rtl/axi_rule_monitor.sv
module axi_rule_monitor
  import axi_rule_pkg::*;
#(
  parameter int RD_DEPTH      = 4,
  parameter int WR_DEPTH      = 4,
  parameter int DATA_BYTES    = 8,
  parameter int MAX_BURST_LEN = 16,
  parameter bit NARROW_OK     = 1'b0,
  parameter bit RESP_CHECK    = 1'b1,
  parameter bit LIGHT_MODE    = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ar_valid,
  input  logic                          ar_ready,
  input  logic [7:0]                    ar_len,
  input  logic [2:0]                    ar_size,
  input  logic                          r_valid,
  input  logic                          r_ready,
  input  logic                          r_last,
  input  logic [1:0]                    r_resp,
  input  logic                          aw_valid,
  input  logic                          aw_ready,
  input  logic [7:0]                    aw_len,
  input  logic [2:0]                    aw_size,
  input  logic                          w_valid,
  input  logic                          w_ready,
  input  logic                          w_last,
  input  logic                          b_valid,
  input  logic                          b_ready,
  input  logic [1:0]                    b_resp,
  output logic [ERR_W-1:0]              err_flags,
  output logic [$clog2(RD_DEPTH+1)-1:0] rd_outstanding,
  output logic [$clog2(WR_DEPTH+1)-1:0] wr_outstanding
);

  localparam int RCNT_W = $clog2(RD_DEPTH+1);
  localparam int WCNT_W = $clog2(WR_DEPTH+1);
  localparam logic [RCNT_W-1:0] RD_FULL_V = RCNT_W'(RD_DEPTH);
  localparam logic [WCNT_W-1:0] WR_FULL_V = WCNT_W'(WR_DEPTH);
  localparam logic [ERR_W-1:0]  KEEP = LIGHT_MODE ? STALL_RULES : {ERR_W{1'b1}};

  logic rst_sync_n;

  arm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // handshakes
  logic ar_hs, r_hs, aw_hs, w_hs, b_hs;
  always_comb begin
    ar_hs = ar_valid & ar_ready;
    r_hs  = r_valid  & r_ready;
    aw_hs = aw_valid & aw_ready;
    w_hs  = w_valid  & w_ready;
    b_hs  = b_valid  & b_ready;
  end

  // address attribute rules, index 0 = read, 1 = write
  logic [1:0][7:0] a_len;
  logic [1:0][2:0] a_size;
  logic [1:0]      len_bad, narrow_bad;

  assign a_len  = {aw_len,  ar_len};
  assign a_size = {aw_size, ar_size};

  for (genvar gi = 0; gi < 2; gi++) begin : g_attr
    arm_attr_check #(
      .MAX_BURST_LEN (MAX_BURST_LEN),
      .DATA_BYTES    (DATA_BYTES),
      .NARROW_OK     (NARROW_OK)
    ) u_attr (
      .len        (a_len[gi]),
      .size       (a_size[gi]),
      .len_bad    (len_bad[gi]),
      .narrow_bad (narrow_bad[gi])
    );
  end

  // read tracking
  logic [RCNT_W-1:0] rd_cnt;
  logic [7:0]        rd_head;
  logic              rd_full, rd_empty, rd_push, rd_pop, r_beat, r_last_err;

  always_comb begin
    rd_full  = (rd_cnt == RD_FULL_V);
    rd_empty = (rd_cnt == '0);
    rd_push  = ar_hs & ~rd_full;
    r_beat   = r_hs & ~rd_empty;
    rd_pop   = r_beat & r_last;
  end

  arm_len_fifo #(.DEPTH(RD_DEPTH), .W(8)) u_rd_q (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (rd_push),
    .push_len (ar_len),
    .pop      (rd_pop),
    .head_len (rd_head),
    .count    (rd_cnt)
  );

  arm_beat_check #(.W(8)) u_r_beats (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .beat     (r_beat),
    .last     (r_last),
    .exp_len  (rd_head),
    .last_err (r_last_err)
  );

  // write tracking: address queue until data completes, then a response count
  logic [WCNT_W-1:0] wq_cnt, b_pend_q, b_pend_d, wr_sum;
  logic [7:0]        wr_head;
  logic              wr_full, wq_empty, wq_push, wq_pop, w_beat, w_last_err;
  logic              b_ok, b_none, b_en;

  always_comb begin
    wr_sum   = wq_cnt + b_pend_q;
    wr_full  = (wr_sum == WR_FULL_V);
    wq_empty = (wq_cnt == '0);
    b_none   = (b_pend_q == '0);
    wq_push  = aw_hs & ~wr_full;
    w_beat   = w_hs & ~wq_empty;
    wq_pop   = w_beat & w_last;
    b_ok     = b_hs & ~b_none;
    b_en     = wq_pop ^ b_ok;
    b_pend_d = wq_pop ? b_pend_q + 1'b1 : b_pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) b_pend_q <= '0;
    else if (b_en)   b_pend_q <= b_pend_d;
  end

  arm_len_fifo #(.DEPTH(WR_DEPTH), .W(8)) u_wr_q (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (wq_push),
    .push_len (aw_len),
    .pop      (wq_pop),
    .head_len (wr_head),
    .count    (wq_cnt)
  );

  arm_beat_check #(.W(8)) u_w_beats (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .beat     (w_beat),
    .last     (w_last),
    .exp_len  (wr_head),
    .last_err (w_last_err)
  );

  // rule collection
  logic [ERR_W-1:0] err_set, err_d, err_q;
  logic             err_en;

  always_comb begin
    err_set              = '0;
    err_set[E_AR_LEN]    = ar_hs & len_bad[0];
    err_set[E_AW_LEN]    = aw_hs & len_bad[1];
    err_set[E_AR_NARROW] = ar_hs & narrow_bad[0];
    err_set[E_AW_NARROW] = aw_hs & narrow_bad[1];
    err_set[E_R_RESP]    = RESP_CHECK & r_hs & resp_is_err(r_resp);
    err_set[E_B_RESP]    = RESP_CHECK & b_hs & resp_is_err(b_resp);
    err_set[E_RD_OVF]    = ar_hs & rd_full;
    err_set[E_WR_OVF]    = aw_hs & wr_full;
    err_set[E_RD_UNF]    = r_hs & rd_empty;
    err_set[E_WR_UNF]    = (w_hs & wq_empty) | (b_hs & b_none);
    err_set[E_R_LAST]    = r_last_err;
    err_set[E_W_LAST]    = w_last_err;
    err_d  = err_q | (err_set & KEEP);
    err_en = |(err_set & KEEP & ~err_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  assign err_flags      = err_q;
  assign rd_outstanding = rd_cnt;
  assign wr_outstanding = wr_sum;

  AST_RD_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ar_hs && rd_cnt == RD_FULL_V) |=> err_q[E_RD_OVF]); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((err_q & $past(err_q)) == $past(err_q))); // R9
  AST_RD_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_cnt == $past(rd_cnt)) || (rd_cnt == $past(rd_cnt) + 1'b1) ||
    (rd_cnt == $past(rd_cnt) - 1'b1)); // R5
  AST_RESP_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (RESP_CHECK && !LIGHT_MODE && r_hs && r_resp[1]) |=> err_q[E_R_RESP]); // R4
  AST_LIGHT_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    LIGHT_MODE |-> (err_q[5:0] == '0)); // R10

endmodule

// File: tb/tb_axi_rule_monitor.sv
`timescale 1ns/1ps
module tb_axi_rule_monitor;

  localparam int RD_D = 4;
  localparam int WR_D = 4;
  localparam int DB   = 8;
  localparam int MAXB = 16;
  localparam int FULL = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
  logic [7:0] ar_len, aw_len;
  logic [2:0] ar_size, aw_size;
  logic [1:0] r_resp, b_resp;
  logic [11:0] err_a, err_l, err_n;
  logic [2:0] rd_a, rd_l, rd_n, wr_a, wr_l, wr_n;

  always #2 clk = ~clk;

  axi_rule_monitor #(.RD_DEPTH(RD_D), .WR_DEPTH(WR_D), .DATA_BYTES(DB),
    .MAX_BURST_LEN(MAXB), .NARROW_OK(1'b0), .RESP_CHECK(1'b1), .LIGHT_MODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len),
    .ar_size(ar_size), .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last), .r_resp(r_resp),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_len(aw_len), .aw_size(aw_size),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last), .b_valid(b_valid),
    .b_ready(b_ready), .b_resp(b_resp), .err_flags(err_a), .rd_outstanding(rd_a),
    .wr_outstanding(wr_a));

  axi_rule_monitor #(.RD_DEPTH(RD_D), .WR_DEPTH(WR_D), .DATA_BYTES(DB),
    .MAX_BURST_LEN(MAXB), .NARROW_OK(1'b0), .RESP_CHECK(1'b1), .LIGHT_MODE(1'b1)) dut_lite (
    .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len),
    .ar_size(ar_size), .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last), .r_resp(r_resp),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_len(aw_len), .aw_size(aw_size),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last), .b_valid(b_valid),
    .b_ready(b_ready), .b_resp(b_resp), .err_flags(err_l), .rd_outstanding(rd_l),
    .wr_outstanding(wr_l));

  axi_rule_monitor #(.RD_DEPTH(RD_D), .WR_DEPTH(WR_D), .DATA_BYTES(DB),
    .MAX_BURST_LEN(MAXB), .NARROW_OK(1'b1), .RESP_CHECK(1'b0), .LIGHT_MODE(1'b0)) dut_loose (
    .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len),
    .ar_size(ar_size), .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last), .r_resp(r_resp),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_len(aw_len), .aw_size(aw_size),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last), .b_valid(b_valid),
    .b_ready(b_ready), .b_resp(b_resp), .err_flags(err_n), .rd_outstanding(rd_n),
    .wr_outstanding(wr_n));

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // ---------------- behavioural reference model ----------------
  int rq[$];
  int wq[$];
  int bpend, rbeat, wbeat, rsz, wsz, bp;
  logic [11:0] exp_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      rq.delete(); wq.delete();
      bpend = 0; rbeat = 0; wbeat = 0; exp_err = '0;
    end else begin
      rsz = rq.size(); wsz = wq.size(); bp = bpend;
      if (ar_valid && ar_ready) begin
        if (int'(ar_len) + 1 > MAXB) exp_err[0] = 1'b1;
        if (int'(ar_size) < FULL)    exp_err[2] = 1'b1;
        if (rsz == RD_D) exp_err[6] = 1'b1; else rq.push_back(int'(ar_len));
      end
      if (r_valid && r_ready) begin
        if (r_resp >= 2'b10) exp_err[4] = 1'b1;
        if (rsz == 0) exp_err[8] = 1'b1;
        else begin
          if (r_last != (rbeat == rq[0])) exp_err[10] = 1'b1;
          if (r_last) begin void'(rq.pop_front()); rbeat = 0; end
          else rbeat++;
        end
      end
      if (aw_valid && aw_ready) begin
        if (int'(aw_len) + 1 > MAXB) exp_err[1] = 1'b1;
        if (int'(aw_size) < FULL)    exp_err[3] = 1'b1;
        if (wsz + bp == WR_D) exp_err[7] = 1'b1; else wq.push_back(int'(aw_len));
      end
      if (w_valid && w_ready) begin
        if (wsz == 0) exp_err[9] = 1'b1;
        else begin
          if (w_last != (wbeat == wq[0])) exp_err[11] = 1'b1;
          if (w_last) begin void'(wq.pop_front()); wbeat = 0; bpend++; end
          else wbeat++;
        end
      end
      if (b_valid && b_ready) begin
        if (b_resp >= 2'b10) exp_err[5] = 1'b1;
        if (bp == 0) exp_err[9] = 1'b1; else bpend--;
      end
    end
  end

  function automatic string tag_of(int bitn, bit lite);
    if (lite && bitn < 6) return "R10";
    case (bitn)
      0, 1:   return "R2";
      2, 3:   return "R3";
      4, 5:   return "R4";
      6, 7:   return "R6";
      8, 9:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp_inst(input string nm, input logic [11:0] act, input logic [11:0] expv,
                          input bit lite, input int ra, input int wa);
    n_tests++;
    for (int i = 0; i < 12; i++)
      if (act[i] !== expv[i]) begin
        n_fail++;
        $display("FAIL %s %s err bit %0d act=%b exp=%b", tag_of(i, lite), nm, i, act[i], expv[i]);
      end
    if (ra != rq.size() || wa != wq.size() + bpend) begin
      n_fail++;
      $display("FAIL R5 %s counts act=%0d/%0d exp=%0d/%0d", nm, ra, wa, rq.size(), wq.size() + bpend);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cmp_inst("full",  err_a, exp_err,            1'b0, int'(rd_a), int'(wr_a));
    cmp_inst("lite",  err_l, exp_err & 12'hFC0,  1'b1, int'(rd_l), int'(wr_l));
    cmp_inst("loose", err_n, exp_err & 12'hFC3,  1'b0, int'(rd_n), int'(wr_n));
  endtask

  task automatic check(input string req, input int act, input int expv, input string what);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic clear_in();
    ar_valid = 0; ar_ready = 0; ar_len = 0; ar_size = 0;
    r_valid = 0; r_ready = 0; r_last = 0; r_resp = 0;
    aw_valid = 0; aw_ready = 0; aw_len = 0; aw_size = 0;
    w_valid = 0; w_ready = 0; w_last = 0; b_valid = 0; b_ready = 0; b_resp = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(); step();
    rst_n = 1'b1; step(); step(); step();
  endtask

  task automatic do_ar(input int len, input int sz);
    ar_valid = 1; ar_ready = 1; ar_len = 8'(len); ar_size = 3'(sz); step(); clear_in();
  endtask
  task automatic do_aw(input int len, input int sz);
    aw_valid = 1; aw_ready = 1; aw_len = 8'(len); aw_size = 3'(sz); step(); clear_in();
  endtask
  task automatic do_r(input int resp, input bit last);
    r_valid = 1; r_ready = 1; r_resp = 2'(resp); r_last = last; step(); clear_in();
  endtask
  task automatic do_w(input bit last);
    w_valid = 1; w_ready = 1; w_last = last; step(); clear_in();
  endtask
  task automatic do_b(input int resp);
    b_valid = 1; b_ready = 1; b_resp = 2'(resp); step(); clear_in();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 1'b0;
    step();
    check("R1", int'(err_a), 0, "flags in reset");
    check("R1", int'(rd_a) + int'(wr_a), 0, "counts in reset");
    do_reset();

    // normal read and write
    do_ar(3, 3);
    check("R5", int'(rd_a), 1, "read outstanding after AR");
    for (int i = 0; i < 4; i++) do_r(0, i == 3);
    check("R5", int'(rd_a), 0, "read outstanding after last");
    do_aw(1, 3); do_w(1'b0); do_w(1'b1);
    check("R5", int'(wr_a), 1, "write waits for response");
    do_b(0);
    check("R8", int'(err_a), 0, "no flag on clean traffic");
    // concurrent address and data
    do_ar(0, 3);
    ar_valid = 1; ar_ready = 1; ar_len = 0; ar_size = 3;
    r_valid = 1; r_ready = 1; r_last = 1; step(); clear_in();
    check("R5", int'(rd_a), 1, "push and pop same cycle");
    do_r(0, 1'b1);

    // burst length
    do_reset();
    do_ar(15, 3);
    check("R2", int'(err_a[0]), 0, "beats equal to cap");
    do_ar(16, 3);
    check("R2", int'(err_a[0]), 1, "read beats over cap");
    do_aw(20, 3);
    check("R2", int'(err_a[1]), 1, "write beats over cap");
    check("R10", int'(err_l[5:0]), 0, "lite drops length rule");

    // narrow
    do_reset();
    do_ar(0, 2); do_aw(0, 3); do_aw(0, 0);
    check("R3", int'(err_a[3:2]), 3, "narrow flagged");
    check("R3", int'(err_n[3:2]), 0, "narrow allowed config");

    // responses
    do_reset();
    do_ar(0, 3); do_r(1, 1'b1);
    check("R4", int'(err_a[4]), 0, "exclusive okay not flagged");
    do_ar(0, 3); do_r(2, 1'b1);
    do_aw(0, 3); do_w(1'b1); do_b(3);
    check("R4", int'(err_a[5:4]), 3, "slave/decode error flagged");
    check("R4", int'(err_n[5:4]), 0, "response check disabled");

    // overflow
    do_reset();
    for (int i = 0; i < 5; i++) do_ar(0, 3);
    check("R6", int'(rd_a), 4, "read count saturates at depth");
    check("R6", int'(err_a[6]), 1, "read overflow");
    check("R10", int'(err_l[6]), 1, "lite keeps overflow");
    for (int i = 0; i < 5; i++) do_aw(0, 3);
    check("R6", int'(err_a[7]), 1, "write overflow");

    // underflow
    do_reset();
    do_r(0, 1'b1);
    check("R7", int'(err_a[8]), 1, "read beat with none outstanding");
    do_b(0);
    check("R7", int'(err_a[9]), 1, "response with no burst");
    check("R7", int'(rd_a), 0, "count stays zero");

    // last placement
    do_reset();
    do_ar(2, 3); do_r(0, 1'b0); do_r(0, 1'b1);
    check("R8", int'(err_a[10]), 1, "early read last");
    check("R8", int'(rd_a), 0, "last ends burst");
    do_aw(0, 3); do_w(1'b0); do_w(1'b1); do_b(0);
    check("R8", int'(err_a[11]), 1, "missing write last");
    check("R10", int'(err_l[11:10]), 3, "lite keeps last rule");

    // stickiness
    for (int i = 0; i < 20; i++) step();
    check("R9", int'(err_a[11:10]), 3, "flags held");
    do_reset();
    check("R1", int'(err_a), 0, "reset clears flags");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule